// File: doc/BRIEF.md
# Byte-Serial Synchronous Master Engine

The engine moves a burst of bytes over a four-wire synchronous serial link as bus master. Software writes one control word that holds the clock polarity and phase, the bit order, the chip-select index and polarity, the manual chip-select mode and the discard mode. Two counts are held outside the block and sampled when a burst starts. The burst length gives the number of bytes clocked on the wire. The transmit length gives how many of those bytes come from a transmit FIFO. Every byte after the transmit length is used up goes out as a 0x00 filler, so a transmit length of zero gives a receive-only burst.

A half-period enable from an outside divider paces the serial clock. The engine pops bytes from a show-ahead transmit FIFO. It pushes each received byte into a receive FIFO unless discard mode is on. When a burst ends it clears its own start bit and raises a one-cycle completion pulse. If the transmit FIFO runs dry while real data is still owed, the link stalls with the clock held at its idle level until data arrives.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control word reads 0, every chip-select line is low, the serial clock is low and no completion pulse is raised. The control word is 32 bits: bit0 enable, bit1 master, bit2 phase, bit3 polarity, bit4 select-active-low, bit6 LSB-first, bit10 start, bits13:12 select index, bit15 discard, bit16 manual select, bit17 manual level. A write replaces the whole word.
- R2: While no burst is pending the serial clock rests at the polarity bit. With phase 0, each bit is launched before the leading clock edge and both sides sample on the leading edge. With phase 1, each bit is launched on the leading edge and sampled on the trailing edge.
- R3: With bit6 clear, each byte goes out and comes in MSB first. With bit6 set, each byte goes out and comes in LSB first.
- R4: A burst clocks exactly burst-length bytes (16 clock edges each). The first transmit-length bytes are popped from the transmit FIFO in order, and every later byte is sent as 0x00.
- R5: With a transmit length of zero, no byte is popped and every byte of the burst is still clocked and received.
- R6: With the discard bit set, no byte is pushed to the receive FIFO. The slave still receives the transmitted bytes.
- R7: If the transmit FIFO is empty while transmit length remains, the serial clock makes no edge and the burst does not complete until a byte is available. The burst then resumes without losing data.
- R8: The start bit clears by itself when a burst finishes. The completion pulse is exactly one cycle wide and comes once per burst.
- R9: In automatic mode the selected line is driven to its active level for the whole burst, starting one serial clock period before the first edge and ending one period after the last edge. Unselected lines, and the selected line when idle, sit at the idle level: high when bit4 is set, low otherwise.
- R10: In manual mode the selected line follows the manual level bit and the other lines sit at the idle level.
- R11: A start bit set while enable or master is clear starts no burst: no clock edge and no completion pulse.
- R12: A burst started with a burst length of zero completes at once, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWdata | input | 32 | Control word write data |
| ctrlRdata | output | 32 | Current control word |
| burstLen | input | CNT_W (24) | Bytes to clock in the burst |
| txLen | input | CNT_W (24) | Bytes taken from the transmit FIFO |
| tick | input | 1 | Half serial-period enable from the divider |
| txData | input | 8 | Head byte of the transmit FIFO |
| txValid | input | 1 | Transmit FIFO not empty |
| txPop | output | 1 | Pop the transmit FIFO head |
| rxData | output | 8 | Received byte |
| rxPush | output | 1 | Push rxData into the receive FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select lines |
| xferDone | output | 1 | One-cycle burst completion pulse |

## Verification
A wrong byte or edge counter shows up at the ports in the same burst. The slave sees the wrong number of clock edges, or a filler appears where FIFO data was due. The pop count disagrees, and the completion pulse comes early or never. A wrong shift-register or phase state shows as corrupted bytes in the slave or the receive FIFO within the first byte. A wrong chip-select or idle-clock state is visible on csOut or sclk on the very cycle it goes wrong, and the bound checker watches those lines on every clock.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int CTRL_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int CS_LINES = 4;
  localparam int SEL_W    = $clog2(CS_LINES);
  localparam int EDGE_W   = $clog2(2 * BYTE_W);

  // control word bit positions (software-visible layout)
  localparam int B_EN     = 0;
  localparam int B_MASTER = 1;
  localparam int B_CPHA   = 2;
  localparam int B_CPOL   = 3;
  localparam int B_ALOW   = 4;
  localparam int B_LSB    = 6;
  localparam int B_START  = 10;
  localparam int B_SEL    = 12;
  localparam int B_DISC   = 15;
  localparam int B_MAN    = 16;
  localparam int B_LVL    = 17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOAD, ST_SHIFT, ST_TRAIL
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic filler;
    logic leadEdge;
    logic trailEdge;
  } xferStb_t;
endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [CTRL_W-1:0]   ctrlWdata,
  output logic [CTRL_W-1:0]   ctrlQ,
  input  logic [CNT_W-1:0]    burstLen,
  input  logic [CNT_W-1:0]    txLen,
  input  logic                tick,
  input  logic                txValid,
  output xferStb_t            stb,
  output logic                txPop,
  output logic                rxPush,
  output logic                xferDone,
  output logic [CS_LINES-1:0] csOut
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

  xferState_t        state;
  logic              halfQ;
  logic [EDGE_W-1:0] edgeQ;
  logic [CNT_W-1:0]  burstLeft;
  logic [CNT_W-1:0]  txLeft;
  logic [CTRL_W-1:0] ctrlNext;
  logic              doneQ, pushQ;
  logic              go, clrStart, lastEdge, txLeftZero;

  assign go         = ctrlQ[B_START] & ctrlQ[B_EN] & ctrlQ[B_MASTER];
  assign txLeftZero = (txLeft == '0);

  always_comb begin
    stb      = '0;
    clrStart = 1'b0;
    case (state)
      ST_IDLE: begin
        stb.clear = 1'b1;
        clrStart  = go && (burstLen == '0);
      end
      ST_LOAD:
        if (txLeftZero || txValid) begin
          stb.load   = 1'b1;
          stb.filler = txLeftZero;
        end
      ST_SHIFT:
        if (tick) begin
          stb.leadEdge  = ~edgeQ[0];
          stb.trailEdge = edgeQ[0];
        end
      ST_TRAIL: clrStart = tick && halfQ;
      default: ;
    endcase
  end

  assign lastEdge = stb.trailEdge && (edgeQ == LAST_EDGE);

  always_comb begin
    ctrlNext = ctrlWr ? ctrlWdata : ctrlQ;
    if (clrStart) ctrlNext[B_START] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ctrlQ     <= '0;
      halfQ     <= 1'b0;
      edgeQ     <= '0;
      burstLeft <= '0;
      txLeft    <= '0;
      doneQ     <= 1'b0;
      pushQ     <= 1'b0;
    end else begin
      ctrlQ <= ctrlNext;
      doneQ <= clrStart;
      pushQ <= lastEdge && !ctrlQ[B_DISC];
      case (state)
        ST_IDLE:
          if (go && (burstLen != '0)) begin
            burstLeft <= burstLen;
            txLeft    <= txLen;
            halfQ     <= 1'b0;
            state     <= ST_LEAD;
          end
        ST_LEAD:
          if (tick) begin
            halfQ <= ~halfQ;
            if (halfQ) state <= ST_LOAD;
          end
        ST_LOAD:
          if (stb.load) begin
            if (!stb.filler) txLeft <= txLeft - CNT_W'(1);
            edgeQ <= '0;
            state <= ST_SHIFT;
          end
        ST_SHIFT:
          if (tick) begin
            edgeQ <= edgeQ + EDGE_W'(1);
            if (lastEdge) begin
              burstLeft <= burstLeft - CNT_W'(1);
              halfQ     <= 1'b0;
              state     <= (burstLeft == CNT_W'(1)) ? ST_TRAIL : ST_LOAD;
            end
          end
        ST_TRAIL:
          if (tick) begin
            halfQ <= ~halfQ;
            if (halfQ) state <= ST_IDLE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txPop    = stb.load & ~stb.filler;
  assign rxPush   = pushQ;
  assign xferDone = doneQ;

  // chip-select drive
  logic idleLvl, selLvl;
  assign idleLvl = ctrlQ[B_ALOW];
  assign selLvl  = ctrlQ[B_MAN] ? ctrlQ[B_LVL]
                 : ((state != ST_IDLE) ? ~idleLvl : idleLvl);

  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    assign csOut[i] = (ctrlQ[B_SEL +: SEL_W] == SEL_W'(i)) ? selLvl : idleLvl;
  end
endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xferStb_t          stb,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rxByte
);
  function automatic logic [BYTE_W-1:0] flip(input logic [BYTE_W-1:0] v);
    for (int i = 0; i < BYTE_W; i++) flip[i] = v[BYTE_W-1-i];
  endfunction

  logic              phaseQ, mosiQ;
  logic [BYTE_W-1:0] txShift, rxShift, ordered, srcByte;
  logic              sampleEdge, launchEdge;

  assign srcByte    = stb.filler ? '0 : txByte;
  assign ordered    = lsbFirst ? flip(srcByte) : srcByte;
  assign sampleEdge = cpha ? stb.trailEdge : stb.leadEdge;
  assign launchEdge = cpha ? stb.leadEdge : stb.trailEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      mosiQ   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.clear) phaseQ <= 1'b0;
      else if (stb.leadEdge || stb.trailEdge) phaseQ <= ~phaseQ;

      if (stb.load) begin
        if (cpha) txShift <= ordered;
        else begin
          mosiQ   <= ordered[BYTE_W-1];
          txShift <= {ordered[BYTE_W-2:0], 1'b0};
        end
      end else if (launchEdge) begin
        mosiQ   <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end

      if (sampleEdge) rxShift <= {rxShift[BYTE_W-2:0], miso};
    end
  end

  assign sclk   = phaseQ ^ cpol;
  assign mosi   = mosiQ;
  assign rxByte = lsbFirst ? flip(rxShift) : rxShift;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [CTRL_W-1:0]   ctrlWdata,
  output logic [CTRL_W-1:0]   ctrlRdata,
  input  logic [CNT_W-1:0]    burstLen,
  input  logic [CNT_W-1:0]    txLen,
  input  logic                tick,
  input  logic [BYTE_W-1:0]   txData,
  input  logic                txValid,
  output logic                txPop,
  output logic [BYTE_W-1:0]   rxData,
  output logic                rxPush,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_LINES-1:0] csOut,
  output logic                xferDone
);
  xferStb_t stb;

  spi_xfer_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .ctrlQ(ctrlRdata), .burstLen(burstLen), .txLen(txLen), .tick(tick),
    .txValid(txValid), .stb(stb), .txPop(txPop), .rxPush(rxPush),
    .xferDone(xferDone), .csOut(csOut)
  );

  spi_xfer_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(txData),
    .cpol(ctrlRdata[B_CPOL]), .cpha(ctrlRdata[B_CPHA]),
    .lsbFirst(ctrlRdata[B_LSB]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxByte(rxData)
  );
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] ctrlRdata,
  input logic        sclk,
  input logic        txPop,
  input logic        txValid,
  input logic        rxPush,
  input logic [3:0]  csOut,
  input logic        xferDone
);
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdata[10] |-> (sclk == ctrlRdata[3]));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  a_r8_done_clears_start: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !ctrlRdata[10]);

  a_r6_no_push_discard: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !$past(ctrlRdata[15]));

  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> txValid);

  a_r10_manual_level: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[16] |-> (csOut[ctrlRdata[13:12]] == ctrlRdata[17]));

  a_r9_cs_active_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclk) && ctrlRdata[10] && $past(ctrlRdata[10]) && !ctrlRdata[16])
      |-> (csOut[ctrlRdata[13:12]] != ctrlRdata[4]));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk i_chk (.*);

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [31:0] ctrlWdata = '0;
  logic [31:0] ctrlRdata;
  logic [CNT_W-1:0] burstLen = '0;
  logic [CNT_W-1:0] txLen = '0;
  logic tick;
  logic [7:0] txData;
  logic txValid, txPop;
  logic [7:0] rxData;
  logic rxPush, sclk, mosi, miso, xferDone;
  logic [3:0] csOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_engine #(.CNT_W(CNT_W)) i_spi_xfer_engine (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .burstLen(burstLen), .txLen(txLen), .tick(tick),
    .txData(txData), .txValid(txValid), .txPop(txPop), .rxData(rxData),
    .rxPush(rxPush), .sclk(sclk), .mosi(mosi), .miso(miso), .csOut(csOut),
    .xferDone(xferDone)
  );

  // divider: one tick every two cycles
  logic tickQ = 1'b0;
  always @(posedge clk) tickQ <= ~tickQ;
  assign tick = tickQ;

  // transmit FIFO model
  logic [7:0] txQ [0:255];
  logic [7:0] txRd = '0;
  logic [7:0] txTop = '0;
  assign txValid = (txRd != txTop);
  assign txData  = txQ[txRd];
  always @(posedge clk) if (txPop) txRd <= txRd + 8'd1;

  // receive FIFO model and counters
  logic [7:0] rxCap [0:255];
  logic [7:0] rxN = '0;
  int popN = 0, doneCnt = 0, doneStreak = 0, doneLong = 0;
  always @(posedge clk) begin
    if (rxPush) begin rxCap[rxN] <= rxData; rxN <= rxN + 8'd1; end
    if (txPop) popN <= popN + 1;
    if (xferDone) doneCnt <= doneCnt + 1;
    doneStreak <= xferDone ? doneStreak + 1 : 0;
    if (xferDone && doneStreak != 0) doneLong <= doneLong + 1;
  end

  // slave model
  logic [7:0] slvTx [0:7];
  logic [7:0] slvRx [0:7];
  bit cpolB, cphaB, lsbB, slvOn;
  logic [3:0] expCs;
  int outIdx = 0, inIdx = 0, outBase = 0, inBase = 0, edgeN = 0, csBad = 0;
  logic misoR = 1'b0;

  function automatic logic wb(input int k);
    int b = k / 8;
    int j = k % 8;
    if (b > 7) return 1'b0;
    return lsbB ? slvTx[b][j] : slvTx[b][7-j];
  endfunction

  assign miso = cphaB ? misoR : wb(outIdx - outBase);

  always @(sclk) begin
    edgeN = edgeN + 1;
    if (slvOn) begin
      if (csOut !== expCs) csBad = csBad + 1;
      if ((sclk != cpolB) != cphaB) begin
        // sampling edge
        if ((inIdx - inBase) < 64)
          slvRx[(inIdx-inBase)/8][lsbB ? (inIdx-inBase)%8 : 7-((inIdx-inBase)%8)] = mosi;
        inIdx = inIdx + 1;
      end else begin
        if (cphaB) misoR = wb(outIdx - outBase);
        outIdx = outIdx + 1;
      end
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [31:0] v);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlWdata = v;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  function automatic logic [31:0] cfg(input bit cpol, cpha, lsb, disc, alow,
                                       input logic [1:0] sel);
    logic [31:0] v = 32'h3;
    v[2] = cpha; v[3] = cpol; v[4] = alow; v[6] = lsb;
    v[13:12] = sel; v[15] = disc;
    return v;
  endfunction

  int eBase, pBase, dBase;
  logic [7:0] rBase;

  task automatic pushTx(input logic [7:0] b);
    txQ[txTop] = b;
    txTop = txTop + 8'd1;
  endtask

  task automatic startBurst(input logic [31:0] c, input int burst, input int txn);
    cpolB = c[3]; cphaB = c[2]; lsbB = c[6];
    burstLen = CNT_W'(burst); txLen = CNT_W'(txn);
    writeCtrl(c);
    outBase = outIdx; inBase = inIdx; eBase = edgeN;
    rBase = rxN; pBase = popN; dBase = doneCnt;
    expCs = c[4] ? ~(4'b1 << c[13:12]) : (4'b1 << c[13:12]);
    slvOn = 1;
    writeCtrl(c | 32'h400);
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (doneCnt == dBase && n < 4000) begin @(negedge clk); n++; end
    chk(doneCnt == dBase + 1, tag, doneCnt - dBase, 1);
    repeat (3) @(negedge clk);
    slvOn = 0;
  endtask

  task automatic testReset();
    chk(ctrlRdata == 32'h0, "R1 ctrl reset", ctrlRdata, 0);
    chk(csOut == 4'h0, "R1 cs reset", csOut, 0);
    chk(sclk == 1'b0 && xferDone == 1'b0, "R1 sclk/done reset", {sclk, xferDone}, 0);
  endtask

  task automatic testMode0();
    logic [31:0] c = cfg(0, 0, 0, 0, 1, 2'd1);
    pushTx(8'hA5); pushTx(8'h3C); pushTx(8'hF0);
    slvTx[0] = 8'h96; slvTx[1] = 8'h11; slvTx[2] = 8'hE7;
    startBurst(c, 3, 3);
    waitDone("R8 mode0 done");
    chk(slvRx[0] == 8'hA5 && slvRx[1] == 8'h3C && slvRx[2] == 8'hF0, "R2 mode0 mosi",
        {slvRx[0], slvRx[1], slvRx[2]}, 24'hA53CF0);
    chk(rxN == rBase + 8'd3, "R4 mode0 rx count", rxN - rBase, 3);
    chk(rxCap[rBase] == 8'h96 && rxCap[rBase+8'd1] == 8'h11 && rxCap[rBase+8'd2] == 8'hE7,
        "R2 mode0 miso", {rxCap[rBase], rxCap[rBase+8'd1], rxCap[rBase+8'd2]}, 24'h9611E7);
    chk(edgeN - eBase == 48, "R4 mode0 edges", edgeN - eBase, 48);
    chk(popN - pBase == 3, "R4 mode0 pops", popN - pBase, 3);
    chk(ctrlRdata[10] == 1'b0, "R8 start cleared", ctrlRdata[10], 0);
    chk(csOut == 4'hF, "R9 idle high", csOut, 4'hF);
    chk(csBad == 0, "R9 cs during burst", csBad, 0);
  endtask

  task automatic testMode3Lsb();
    logic [31:0] c = cfg(1, 1, 1, 0, 0, 2'd3);
    pushTx(8'h01); pushTx(8'hC8);
    slvTx[0] = 8'h80; slvTx[1] = 8'h5A;
    startBurst(c, 2, 2);
    waitDone("R8 mode3 done");
    chk(slvRx[0] == 8'h01 && slvRx[1] == 8'hC8, "R3 lsb mosi", {slvRx[0], slvRx[1]}, 16'h01C8);
    chk(rxCap[rBase] == 8'h80 && rxCap[rBase+8'd1] == 8'h5A, "R3 lsb miso",
        {rxCap[rBase], rxCap[rBase+8'd1]}, 16'h805A);
    chk(sclk == 1'b1, "R2 idle at cpol", sclk, 1);
    chk(csOut == 4'h0 && csBad == 0, "R9 active high cs", {csBad, csOut}, 0);
  endtask

  task automatic testFiller();
    logic [31:0] c = cfg(0, 1, 0, 0, 1, 2'd0);
    pushTx(8'h7E); pushTx(8'h42); pushTx(8'h99);
    slvTx[0] = 8'h12; slvTx[1] = 8'h34; slvTx[2] = 8'h56; slvTx[3] = 8'h78;
    startBurst(c, 4, 2);
    waitDone("R8 filler done");
    chk(slvRx[0] == 8'h7E && slvRx[1] == 8'h42 && slvRx[2] == 8'h00 && slvRx[3] == 8'h00,
        "R4 filler bytes", {slvRx[0], slvRx[1], slvRx[2], slvRx[3]}, 32'h7E420000);
    chk(popN - pBase == 2, "R4 filler pops", popN - pBase, 2);
    chk(rxCap[rBase+8'd3] == 8'h78, "R4 last rx", rxCap[rBase+8'd3], 8'h78);
    txRd = txTop; // discard the spare byte
  endtask

  task automatic testRxOnly();
    logic [31:0] c = cfg(1, 0, 0, 0, 1, 2'd2);
    slvTx[0] = 8'hDE; slvTx[1] = 8'hAD;
    startBurst(c, 2, 0);
    waitDone("R8 rx-only done");
    chk(popN == pBase, "R5 no pops", popN - pBase, 0);
    chk(rxCap[rBase] == 8'hDE && rxCap[rBase+8'd1] == 8'hAD, "R5 rx data",
        {rxCap[rBase], rxCap[rBase+8'd1]}, 16'hDEAD);
    chk(slvRx[0] == 8'h00 && slvRx[1] == 8'h00, "R5 filler out", {slvRx[0], slvRx[1]}, 0);
  endtask

  task automatic testDiscard();
    logic [31:0] c = cfg(0, 0, 0, 1, 1, 2'd1);
    pushTx(8'h55); pushTx(8'hAA);
    startBurst(c, 2, 2);
    waitDone("R8 discard done");
    chk(rxN == rBase, "R6 no push", rxN - rBase, 0);
    chk(slvRx[0] == 8'h55 && slvRx[1] == 8'hAA, "R6 still sent", {slvRx[0], slvRx[1]}, 16'h55AA);
  endtask

  task automatic testStall();
    logic [31:0] c = cfg(0, 0, 0, 0, 1, 2'd0);
    startBurst(c, 1, 1);
    repeat (60) @(negedge clk);
    chk(edgeN == eBase, "R7 no edge while empty", edgeN - eBase, 0);
    chk(doneCnt == dBase, "R7 no done while empty", doneCnt - dBase, 0);
    pushTx(8'hB4);
    waitDone("R7 resumes");
    chk(slvRx[0] == 8'hB4, "R7 data after stall", slvRx[0], 8'hB4);
    chk(doneLong == 0, "R8 pulse width", doneLong, 0);
  endtask

  task automatic testZero();
    logic [31:0] c = cfg(0, 0, 0, 0, 1, 2'd0);
    startBurst(c, 0, 0);
    repeat (5) @(negedge clk);
    chk(doneCnt == dBase + 1, "R12 zero done", doneCnt - dBase, 1);
    chk(edgeN == eBase, "R12 zero edges", edgeN - eBase, 0);
    chk(ctrlRdata[10] == 1'b0, "R12 start cleared", ctrlRdata[10], 0);
    slvOn = 0;
  endtask

  task automatic testNoEnable();
    int e0, d0;
    writeCtrl(32'h0000_0410);
    e0 = edgeN; d0 = doneCnt;
    repeat (80) @(negedge clk);
    chk(edgeN == e0 && doneCnt == d0, "R11 no burst", (edgeN - e0) + (doneCnt - d0), 0);
    writeCtrl(32'h0000_0412);
    repeat (40) @(negedge clk);
    chk(edgeN == e0 && doneCnt == d0, "R11 master only", (edgeN - e0) + (doneCnt - d0), 0);
    writeCtrl(32'h0);
  endtask

  task automatic testManual();
    writeCtrl(32'h0003_2013);
    chk(csOut == 4'hF, "R10 manual high", csOut, 4'hF);
    writeCtrl(32'h0001_2013);
    chk(csOut == 4'hB, "R10 manual low", csOut, 4'hB);
    writeCtrl(32'h0003_2003);
    chk(csOut == 4'h4, "R10 manual high, idle low", csOut, 4'h4);
    chk(ctrlRdata == 32'h0003_2003, "R1 readback", ctrlRdata, 32'h0003_2003);
  endtask

  initial begin
    slvOn = 0; expCs = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testMode0();
    testMode3Lsb();
    testFiller();
    testRxOnly();
    testDiscard();
    testStall();
    testZero();
    testNoEnable();
    testManual();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule